// File: doc/BRIEF.md
# Four-Channel Output Compare Timer

A free-running 16-bit up-counter feeds four output compare channels. Each channel owns one port pin. When a channel is armed for output compare and the counter equals that channel's compare value on a counting cycle, the channel latches a sticky flag. Channels 0 to 2 then perform their own pin action: hold, toggle, drive low or drive high. Channel 3 is the master channel. On its match it writes a data pattern onto every pin selected by its mask register. That pattern beats any action that channels 0 to 2 schedule for the same pin in the same cycle.

Software reaches the block through a plain single-cycle register bus with a combinational read path. Through this bus it sets the compare values, the arm bits, the action fields, the master mask and data, the data-direction bits and the pin data. Each pin's output-enable is its data-direction bit, or the case where its channel is armed and its master-mask bit is set. This forcing never alters the stored data-direction register.

Register addresses used by the bus: 0 counter, 1 arm bits, 2 action fields, 3 flags, 4 master mask, 5 master data, 6 data direction, 7 pin data, 8+n compare value of channel n.

Top module: `ocmp_timer`

## Requirements
- R1: The counter resets to 0, advances by one on each clock edge where `cnt_en` is 1, holds otherwise, wraps from 0xFFFF to 0x0000, and a bus write to address 0 leaves it unchanged.
- R2: Channel n matches on an edge where `cnt_en` is 1, arm bit n (address 1, bit n) is 1 and the counter equals the compare value at address 8+n. Without a match or a write to address 7, pin data does not change.
- R3: On a match of channel n (n = 0..2), pin n follows action field bits [2n+1:2n] of address 2: 00 hold, 01 toggle, 10 drive 0, 11 drive 1. The result is visible on `pin_out` after that edge.
- R4: On a channel 3 match, every pin i whose master-mask bit i (address 4) is 1 takes master-data bit i (address 5). Pins whose mask bit is 0 are not touched by channel 3.
- R5: When channel 3 and a channel 0..2 act on the same pin in the same edge, the pin takes the channel 3 value. A compare action also beats a same-edge bus write to address 7 on that pin.
- R6: `pin_oe[i]` equals data-direction bit i (address 6) OR (arm bit i AND master-mask bit i).
- R7: The data-direction register changes only by a bus write to address 6. Setting mask or arm bits leaves its read value unchanged.
- R8: Bits 15..4 of the mask and data registers read as 0 and ignore writes. All register bits reset to 0.
- R9: Flag n (address 3, bit n) sets on a match of channel n and stays set until a write with bit n = 1 to address 3 clears it. A match in the same edge as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable; one counter step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_out | output | 4 | Port pin data |
| pin_oe | output | 4 | Port pin output-enable |

## Verification
A wrong match decision or priority inside the block shows up on `pin_out` one edge after the counting cycle that should or should not have matched. It also shows as a wrong flag value read back on the next bus read. A corrupted arm, mask or data-direction bit shows on `pin_oe` in the cycle right after the write that exposes it. A counter that wraps or holds wrongly is visible at once through the counter read and through compares that fire at the wrong step. The sweeps cover every mask and data pair under all action codes, so a broken override shows within a few cycles of the first affected pair.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } act_e;

   localparam int unsigned A_CNT  = 0;
   localparam int unsigned A_ARM  = 1;
   localparam int unsigned A_ACT  = 2;
   localparam int unsigned A_FLAG = 3;
   localparam int unsigned A_MASK = 4;
   localparam int unsigned A_DATA = 5;
   localparam int unsigned A_DDR  = 6;
   localparam int unsigned A_PORT = 7;
   localparam int unsigned A_CMP0 = 8;

endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [CW-1:0] cnt
);

   generate
      if (CW < 2) begin : g_bad_width
         $error("ocmp_counter: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (en)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en,
   input  logic          armed,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp,
   input  logic          flag_clr,
   output logic          match,
   output logic          flag
);

   assign match = cnt_en & armed & (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else
         flag <= (flag & ~flag_clr) | match;
   end

endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs
   import ocmp_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16,
   parameter int unsigned DW  = 16,
   parameter int unsigned AW  = 4,
   localparam int unsigned ACTW = 2 * (NCH - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   input  logic [CW-1:0]     cnt,
   input  logic [NCH-1:0]    flag,
   input  logic [NCH-1:0]    port,
   output logic [NCH-1:0]    arm,
   output logic [ACTW-1:0]   act,
   output logic [NCH-1:0]    mask,
   output logic [NCH-1:0]    data3,
   output logic [NCH-1:0]    ddr,
   output logic [NCH*CW-1:0] cmp_flat,
   output logic [NCH-1:0]    flag_clr,
   output logic              port_we,
   output logic [DW-1:0]     rdata
);

   function automatic logic hit(input logic [AW-1:0] a, input int unsigned target);
      return a == AW'(target);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm   <= '0;
         act   <= '0;
         mask  <= '0;
         data3 <= '0;
         ddr   <= '0;
      end else if (wr) begin
         if (hit(addr, A_ARM))  arm   <= wdata[NCH-1:0];
         if (hit(addr, A_ACT))  act   <= wdata[ACTW-1:0];
         if (hit(addr, A_MASK)) mask  <= wdata[NCH-1:0];
         if (hit(addr, A_DATA)) data3 <= wdata[NCH-1:0];
         if (hit(addr, A_DDR))  ddr   <= wdata[NCH-1:0];
      end
   end

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)
               cmp_flat[n*CW +: CW] <= '0;
            else if (wr && hit(addr, A_CMP0 + n))
               cmp_flat[n*CW +: CW] <= wdata[CW-1:0];
         end
      end
   endgenerate

   assign flag_clr = (wr && hit(addr, A_FLAG)) ? wdata[NCH-1:0] : '0;
   assign port_we  = wr && hit(addr, A_PORT);

   always_comb begin
      rdata = '0;
      if (hit(addr, A_CNT))  rdata = DW'(cnt);
      if (hit(addr, A_ARM))  rdata = DW'(arm);
      if (hit(addr, A_ACT))  rdata = DW'(act);
      if (hit(addr, A_FLAG)) rdata = DW'(flag);
      if (hit(addr, A_MASK)) rdata = DW'(mask);
      if (hit(addr, A_DATA)) rdata = DW'(data3);
      if (hit(addr, A_DDR))  rdata = DW'(ddr);
      if (hit(addr, A_PORT)) rdata = DW'(port);
      for (int n = 0; n < NCH; n++)
         if (hit(addr, A_CMP0 + n)) rdata = DW'(cmp_flat[n*CW +: CW]);
   end

endmodule

// File: rtl/ocmp_pin_ctrl.sv
module ocmp_pin_ctrl
   import ocmp_pkg::*;
#(
   parameter int unsigned NCH = 4,
   localparam int unsigned ACTW = 2 * (NCH - 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_we,
   input  logic [NCH-1:0]  port_wdata,
   input  logic [NCH-1:0]  match,
   input  logic [ACTW-1:0] act,
   input  logic [NCH-1:0]  arm,
   input  logic [NCH-1:0]  mask,
   input  logic [NCH-1:0]  data3,
   input  logic [NCH-1:0]  ddr,
   output logic [NCH-1:0]  port_q,
   output logic [NCH-1:0]  oe
);

   localparam int unsigned MST = NCH - 1;

   logic [NCH-1:0] nxt;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_pin
         logic base;
         logic own;
         assign base = port_we ? port_wdata[i] : port_q[i];

         if (i < MST) begin : g_act
            act_e code;
            assign code = act_e'(act[2*i +: 2]);
            always_comb begin
               own = base;
               if (match[i]) begin
                  unique case (code)
                     ACT_HOLD:   own = base;
                     ACT_TOGGLE: own = ~port_q[i];
                     ACT_LOW:    own = 1'b0;
                     ACT_HIGH:   own = 1'b1;
                  endcase
               end
            end
         end else begin : g_noact
            assign own = base;
         end

         assign nxt[i] = (match[MST] && mask[i]) ? data3[i] : own;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         port_q <= '0;
      else
         port_q <= nxt;
   end

   assign oe = ddr | (arm & mask);

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
   import ocmp_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16,
   parameter int unsigned DW  = 16,
   parameter int unsigned AW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cnt_en,
   input  logic           bus_wr,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] pin_out,
   output logic [NCH-1:0] pin_oe
);

   localparam int unsigned ACTW = 2 * (NCH - 1);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("ocmp_timer: NCH must be at least 2");
      end
      if (DW < CW || DW < NCH || DW < ACTW) begin : g_bad_dw
         $error("ocmp_timer: DW too narrow for the register fields");
      end
      if ((2 ** AW) < (A_CMP0 + NCH)) begin : g_bad_aw
         $error("ocmp_timer: AW too narrow for the compare registers");
      end
   endgenerate

   logic [CW-1:0]     cnt_q;
   logic [NCH-1:0]    arm;
   logic [ACTW-1:0]   act;
   logic [NCH-1:0]    mask;
   logic [NCH-1:0]    data3;
   logic [NCH-1:0]    ddr;
   logic [NCH*CW-1:0] cmp_flat;
   logic [NCH-1:0]    flag_clr;
   logic              port_we;
   logic [NCH-1:0]    match;
   logic [NCH-1:0]    flag;

   ocmp_counter #(.CW(CW)) u_cnt (
      .clk (clk),
      .rst_n (rst_n),
      .en (cnt_en),
      .cnt (cnt_q)
   );

   ocmp_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .wr (bus_wr),
      .addr (bus_addr),
      .wdata (bus_wdata),
      .cnt (cnt_q),
      .flag (flag),
      .port (pin_out),
      .arm (arm),
      .act (act),
      .mask (mask),
      .data3 (data3),
      .ddr (ddr),
      .cmp_flat (cmp_flat),
      .flag_clr (flag_clr),
      .port_we (port_we),
      .rdata (bus_rdata)
   );

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         ocmp_channel #(.CW(CW)) u_ch (
            .clk (clk),
            .rst_n (rst_n),
            .cnt_en (cnt_en),
            .armed (arm[n]),
            .cnt (cnt_q),
            .cmp (cmp_flat[n*CW +: CW]),
            .flag_clr (flag_clr[n]),
            .match (match[n]),
            .flag (flag[n])
         );
      end
   endgenerate

   ocmp_pin_ctrl #(.NCH(NCH)) u_pins (
      .clk (clk),
      .rst_n (rst_n),
      .port_we (port_we),
      .port_wdata (bus_wdata[NCH-1:0]),
      .match (match),
      .act (act),
      .arm (arm),
      .mask (mask),
      .data3 (data3),
      .ddr (ddr),
      .port_q (pin_out),
      .oe (pin_oe)
   );

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk
   import ocmp_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16,
   parameter int unsigned AW  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_en,
   input logic              bus_wr,
   input logic [AW-1:0]     bus_addr,
   input logic [CW-1:0]     cnt,
   input logic [NCH*CW-1:0] cmp_flat,
   input logic [NCH-1:0]    arm,
   input logic [NCH-1:0]    mask,
   input logic [NCH-1:0]    data3,
   input logic [NCH-1:0]    ddr,
   input logic [NCH-1:0]    flag,
   input logic [NCH-1:0]    pin_out
);

   logic mst_hit;
   logic wr_ddr;
   logic wr_flag;
   logic wr_port;

   assign mst_hit = cnt_en && arm[NCH-1] && (cnt == cmp_flat[(NCH-1)*CW +: CW]);
   assign wr_ddr  = bus_wr && (bus_addr == AW'(A_DDR));
   assign wr_flag = bus_wr && (bus_addr == AW'(A_FLAG));
   assign wr_port = bus_wr && (bus_addr == AW'(A_PORT));

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> cnt == $past(cnt) + 1'b1);

   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt));

   // R2
   pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !wr_port) |=> $stable(pin_out));

   // R5
   mst_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_hit |=> ((pin_out ^ $past(data3)) & $past(mask)) == '0);

   // R7
   ddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ddr |=> $stable(ddr));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> (flag & $past(flag)) == $past(flag));

endmodule

bind ocmp_timer ocmp_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .cnt_en (cnt_en),
   .bus_wr (bus_wr),
   .bus_addr (bus_addr),
   .cnt (cnt_q),
   .cmp_flat (cmp_flat),
   .arm (arm),
   .mask (mask),
   .data3 (data3),
   .ddr (ddr),
   .flag (flag),
   .pin_out (pin_out)
);

// File: tb/ocmp_timer_tb.sv
`timescale 1ns/1ps
module ocmp_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  pin_out;
   logic [3:0]  pin_oe;

   int vectors = 0;
   int miss = 0;
   bit done = 1'b0;

   logic [15:0] m_cnt = '0;
   logic [3:0]  m_arm = '0, m_mask = '0, m_data = '0, m_ddr = '0;
   logic [3:0]  m_flag = '0, m_port = '0;
   logic [5:0]  m_act = '0;
   logic [15:0] m_cmp [4];

   always #5 clk = ~clk;

   ocmp_timer u_dut (
      .clk (clk), .rst_n (rst_n), .cnt_en (cnt_en), .bus_wr (bus_wr),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .pin_out (pin_out), .pin_oe (pin_oe)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] a, input logic [15:0] e);
      vectors++;
      if (!ok) begin
         miss++;
         $display("FAIL %s actual=%h expected=%h", tag, a, e);
      end
   endtask

   task automatic tick();
      logic [3:0] mt, np, nf, clr;
      for (int n = 0; n < 4; n++)
         mt[n] = cnt_en & m_arm[n] & (m_cnt == m_cmp[n]);
      np = m_port;
      if (bus_wr && bus_addr == 4'd7) np = bus_wdata[3:0];
      for (int i = 0; i < 3; i++)
         if (mt[i])
            case (m_act[2*i +: 2])
               2'b01: np[i] = ~m_port[i];
               2'b10: np[i] = 1'b0;
               2'b11: np[i] = 1'b1;
               default: ;
            endcase
      for (int i = 0; i < 4; i++)
         if (mt[3] && m_mask[i]) np[i] = m_data[i];
      clr = (bus_wr && bus_addr == 4'd3) ? bus_wdata[3:0] : 4'h0;
      nf = (m_flag & ~clr) | mt;
      @(posedge clk);
      m_port = np;
      m_flag = nf;
      if (cnt_en) m_cnt = m_cnt + 16'd1;
      if (bus_wr) begin
         case (bus_addr)
            4'd1: m_arm  = bus_wdata[3:0];
            4'd2: m_act  = bus_wdata[5:0];
            4'd4: m_mask = bus_wdata[3:0];
            4'd5: m_data = bus_wdata[3:0];
            4'd6: m_ddr  = bus_wdata[3:0];
            4'd8, 4'd9, 4'd10, 4'd11: m_cmp[bus_addr - 4'd8] = bus_wdata;
            default: ;
         endcase
      end
      @(negedge clk);
      bus_wr = 1'b0;
      cnt_en = 1'b0;
      chk(pin_out == m_port, "R2 R3 R4 R5 pin_out", {12'h0, pin_out}, {12'h0, m_port});
      chk(pin_oe == (m_ddr | (m_arm & m_mask)), "R6 pin_oe", {12'h0, pin_oe},
          {12'h0, m_ddr | (m_arm & m_mask)});
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input bit en = 1'b0);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cnt_en = en;
      tick();
   endtask

   task automatic step();
      cnt_en = 1'b1;
      tick();
   endtask

   task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata == e, tag, bus_rdata, e);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         miss++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", vectors, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < 4; n++) m_cmp[n] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 R10-style reset state: every register and pin at zero
      for (int a = 0; a < 12; a++) rd(4'(a), 16'h0, "R8 reset register value");
      chk(pin_out == 4'h0, "R8 reset pin_out", {12'h0, pin_out}, 16'h0);
      chk(pin_oe == 4'h0, "R6 reset pin_oe", {12'h0, pin_oe}, 16'h0);

      // R1 counting, holding and write to counter ignored
      for (int k = 0; k < 5; k++) step();
      tick();
      rd(4'd0, 16'd5, "R1 count after five steps");
      wr(4'd0, 16'hABCD);
      rd(4'd0, 16'd5, "R1 counter write ignored");

      // R8 reserved bits of mask and data
      wr(4'd4, 16'hFFF0);
      rd(4'd4, 16'h0000, "R8 mask reserved bits");
      wr(4'd5, 16'hFFFF);
      rd(4'd5, 16'h000F, "R8 data reserved bits");
      wr(4'd5, 16'h0000);

      // R6 R7 output-enable sweep; data direction never moved by mask or arm
      for (int am = 0; am < 16; am++)
         for (int mk = 0; mk < 16; mk++) begin
            wr(4'd6, 16'(mk ^ am));
            wr(4'd1, 16'(am));
            wr(4'd4, 16'(mk));
            rd(4'd6, 16'(mk ^ am), "R7 ddr after arm and mask writes");
            for (int dd = 0; dd < 16; dd += 5) wr(4'd6, 16'(dd));
         end
      wr(4'd6, 16'h0);

      // R2 R3 R4 R5 R9 sweep over every mask and data pair
      for (int mk = 0; mk < 16; mk++)
         for (int dt = 0; dt < 16; dt++) begin
            logic [15:0] tgt;
            tgt = m_cnt + 16'd1;
            wr(4'd4, 16'(mk));
            wr(4'd5, 16'(dt));
            wr(4'd2, {10'h0, 2'((dt + 2) % 4), 2'((dt + 1) % 4), 2'(dt % 4)});
            wr(4'd1, (dt % 2 == 0) ? 16'hF : 16'((mk ^ dt) & 15));
            wr(4'd7, 16'((mk * 3 + dt) & 15));
            for (int n = 0; n < 4; n++) wr(4'(8 + n), tgt);
            step();
            if (mk % 2 == 1) wr(4'd3, 16'hF, 1'b1);
            else step();
            rd(4'd3, {12'h0, m_flag}, "R9 flags after match");
            wr(4'd3, 16'hF);
            rd(4'd3, 16'h0, "R9 flags after clear");
         end

      // R5 compare action beats a same-edge pin data write
      wr(4'd1, 16'h1);
      wr(4'd2, 16'h3);
      wr(4'd4, 16'h0);
      wr(4'd8, m_cnt);
      wr(4'd7, 16'h0, 1'b1);
      chk(pin_out[0] == 1'b1, "R5 compare beats port write", {15'h0, pin_out[0]}, 16'h1);

      // R1 R2 wrap: channel 0 toggles once per full counter period
      begin
         logic [15:0] start;
         wr(4'd2, 16'h1);
         wr(4'd8, 16'h0);
         start = m_cnt;
         for (int k = 0; k < 65536; k++) step();
         rd(4'd0, start, "R1 counter after full period");
         rd(4'd3, {12'h0, m_flag}, "R9 flag after wrap match");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   end

endmodule